// File: doc/BRIEF.md
# Two-Word XXTEA Encryption Core

This core encrypts a single 64-bit block, held as two 32-bit words, with the XXTEA block cipher under a 128-bit key. The key lives inside the core as four 32-bit words in a small register memory. The memory has a write port for loading and a combinational read port, so the word each round needs is ready in the same cycle.

A host loads the key words while the core is idle. It then presents the plaintext and pulses start. The core captures the block and performs one full cipher cycle per clock, 32 in all. Each clock updates both words: the first word with the key word chosen by the running sum, then the second word from the freshly updated first word. Once the last cycle has been applied, done pulses for one clock and the ciphertext stays on the output until the next start. Decryption and other block lengths are not provided.

Top module: `xxtea_enc`

## Requirements
- R1: While rst is high, and in the first cycle after it falls, busy and done are 0, ctOut is all zeros, and all four key words read as zero.
- R2: When keyWe is high and busy is low at a rising edge, keyData is stored as key word number keyAddr (0 to 3). The 128-bit key is the four words taken in that index order.
- R3: A start sampled while busy is low captures ptIn. Bits 31:0 become word v0 and bits 63:32 become word v1. Later changes on ptIn do not affect the running encryption.
- R4: busy is high for exactly 32 cycles after the edge that samples start. done is high for exactly one cycle, in the cycle after busy falls, and busy and done are never high together.
- R5: ctOut equals the XXTEA encryption of the captured block, with bits 31:0 as v0 and bits 63:32 as v1. The sum starts at 0 and gains 0x9E3779B9 each cycle. Then v0 += MX(y=z=v1) and v1 += MX(y=z=new v0). MX = (((z>>5)^(y<<2)) + ((y>>3)^(z<<4))) ^ ((sum^y) + (k^z)), modulo 2^32, with logical shifts.
- R6: In each cycle the v0 update uses key word sum[3:2], and the v1 update uses key word sum[3:2] XOR 1, where sum is the value after that cycle's addition.
- R7: A start pulse while busy is high is ignored. The latency and the result of the running encryption do not change.
- R8: A key write attempted while busy is high is ignored. Neither the running encryption nor any later one sees the written data.
- R9: While idle and without a new start, ctOut holds its value, whatever happens on ptIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin encrypting ptIn (ignored while busy) |
| ptIn | input | 64 | Plaintext block, v1 in bits 63:32, v0 in bits 31:0 |
| keyWe | input | 1 | Key word write enable (ignored while busy) |
| keyAddr | input | 2 | Key word index |
| keyData | input | 32 | Key word to store |
| busy | output | 1 | Encryption in progress |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |
| ctOut | output | 64 | Ciphertext block, v1 in bits 63:32, v0 in bits 31:0 |

## Verification
Several properties are checked on every cycle:
- done and busy are never high together.
- done is a single-cycle pulse.
- The round counter advances by one per busy cycle and ends the run on its last value.
- A start seen while busy is therefore ignored.
- The key memory is frozen while busy.
- The output holds while idle.
- A load copies the plaintext into the block.

Whether the arithmetic is right can be shown only by the bench's scenarios. It compares ctOut with its own XXTEA model over directed and random keys and blocks, and this also exercises the key-word selection from sum bits 3:2. The bench also shows the ignored start, key write and plaintext change at the ports.

// File: rtl/xxtea_pkg.sv
package xxtea_pkg;
  localparam int WORD_W    = 32;
  localparam int KEY_WORDS = 4;
  localparam int KIDX_W    = $clog2(KEY_WORDS);
  localparam int BLOCK_W   = 2 * WORD_W;
  localparam logic [WORD_W-1:0] DELTA = 32'h9E37_79B9;

  typedef logic [WORD_W-1:0] word_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture plaintext, clear sum
    logic step;   // apply one cipher cycle
  } ctrl_t;

  // mixing function of the cipher
  function automatic word_t mixWord(word_t y, word_t z, word_t s, word_t k);
    word_t shiftMix;
    word_t keyMix;
    shiftMix = ((z >> 5) ^ (y << 2)) + ((y >> 3) ^ (z << 4));
    keyMix   = (s ^ y) + (k ^ z);
    return shiftMix ^ keyMix;
  endfunction
endpackage

// File: rtl/xxtea_ctrl.sv
module xxtea_ctrl
  import xxtea_pkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  output ctrl_t ctrl,
  output logic  busy,
  output logic  done
);
  localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  typedef enum logic {IDLE, RUN} state_t;

  state_t          state;
  logic [CNT_W-1:0] roundCnt;
  logic            doneQ;
  logic            lastRound;

  assign lastRound = (roundCnt == LAST);

  always_comb begin
    ctrl.load = (state == IDLE) && start;
    ctrl.step = (state == RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= IDLE;
      roundCnt <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        IDLE: if (start) begin
          state    <= RUN;
          roundCnt <= '0;
        end
        RUN: if (lastRound) begin
          state <= IDLE;
          doneQ <= 1'b1;
        end else begin
          roundCnt <= roundCnt + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy = (state == RUN);
  assign done = doneQ;

  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(doneQ && state == RUN));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RUN && !lastRound) |=>
      (state == RUN && roundCnt == CNT_W'($past(roundCnt) + 1'b1)));

  // R4
  round_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RUN && lastRound) |=> (state == IDLE && doneQ));
endmodule

// File: rtl/xxtea_dp.sv
module xxtea_dp
  import xxtea_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrl,
  input  logic               busy,
  input  logic               keyWe,
  input  logic [KIDX_W-1:0]  keyAddr,
  input  word_t              keyData,
  input  logic [BLOCK_W-1:0] ptIn,
  output logic [BLOCK_W-1:0] ctOut
);
  logic [KEY_WORDS-1:0][WORD_W-1:0] keyMem;
  word_t v0, v1, sum;
  word_t sumNext, keyA, keyB, v0New, v1New;
  logic [KIDX_W-1:0] eIdx;

  // key memory: one register word per entry, writes locked while busy
  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    always_ff @(posedge clk) begin
      if (rst)
        keyMem[i] <= '0;
      else if (keyWe && !busy && keyAddr == KIDX_W'(i))
        keyMem[i] <= keyData;
    end
  end

  // one full cycle of the two-word cipher, combinational key read
  always_comb begin
    sumNext = sum + DELTA;
    eIdx    = sumNext[KIDX_W+1:2];
    keyA    = keyMem[eIdx];
    keyB    = keyMem[eIdx ^ KIDX_W'(1)];
    v0New   = v0 + mixWord(v1, v1, sumNext, keyA);
    v1New   = v1 + mixWord(v0New, v0New, sumNext, keyB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v0  <= '0;
      v1  <= '0;
      sum <= '0;
    end else if (ctrl.load) begin
      v0  <= ptIn[WORD_W-1:0];
      v1  <= ptIn[BLOCK_W-1:WORD_W];
      sum <= '0;
    end else if (ctrl.step) begin
      v0  <= v0New;
      v1  <= v1New;
      sum <= sumNext;
    end
  end

  assign ctOut = {v1, v0};

  // R8
  key_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(keyMem));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.load && !ctrl.step) |=> $stable(ctOut));

  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.load |=> (ctOut == $past(ptIn)));
endmodule

// File: rtl/xxtea_enc.sv
module xxtea_enc
  import xxtea_pkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [63:0] ptIn,
  input  logic        keyWe,
  input  logic [1:0]  keyAddr,
  input  logic [31:0] keyData,
  output logic        busy,
  output logic        done,
  output logic [63:0] ctOut
);
  ctrl_t ctrl;

  xxtea_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  xxtea_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .busy    (busy),
    .keyWe   (keyWe),
    .keyAddr (keyAddr),
    .keyData (keyData),
    .ptIn    (ptIn),
    .ctOut   (ctOut)
  );
endmodule

// File: tb/xxtea_enc_test.sv
`timescale 1ns/1ps
module xxtea_enc_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [63:0] ptIn;
  logic        keyWe;
  logic [1:0]  keyAddr;
  logic [31:0] keyData;
  logic        busy, done;
  logic [63:0] ctOut;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [31:0] bk [4];

  always #2.5 clk = ~clk;

  xxtea_enc uut (
    .clk(clk), .rst(rst), .start(start), .ptIn(ptIn), .keyWe(keyWe),
    .keyAddr(keyAddr), .keyData(keyData), .busy(busy), .done(done),
    .ctOut(ctOut)
  );

  // independent model of the two-word cipher, 32 cycles
  function automatic logic [63:0] refEnc(logic [31:0] k0, logic [31:0] k1,
                                         logic [31:0] k2, logic [31:0] k3,
                                         logic [63:0] blk);
    logic [31:0] kk [4];
    logic [31:0] a, b, s, m;
    logic [1:0]  e;
    kk[0] = k0; kk[1] = k1; kk[2] = k2; kk[3] = k3;
    a = blk[31:0];
    b = blk[63:32];
    s = 32'd0;
    for (int r = 0; r < 32; r++) begin
      s = s + 32'h9E37_79B9;
      e = s[3:2];
      m = (((b >> 5) ^ (b << 2)) + ((b >> 3) ^ (b << 4))) ^ ((s ^ b) + (kk[e] ^ b));
      a = a + m;
      m = (((a >> 5) ^ (a << 2)) + ((a >> 3) ^ (a << 4))) ^ ((s ^ a) + (kk[e ^ 2'd1] ^ a));
      b = b + m;
    end
    return {b, a};
  endfunction

  function automatic logic [63:0] expCt(logic [63:0] blk);
    return refEnc(bk[0], bk[1], bk[2], bk[3], blk);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeKey(int idx, logic [31:0] val);
    @(negedge clk);
    keyWe = 1'b1; keyAddr = 2'(idx); keyData = val;
    @(negedge clk);
    keyWe = 1'b0;
    bk[idx] = val;
  endtask

  task automatic loadKey(logic [31:0] k0, logic [31:0] k1,
                         logic [31:0] k2, logic [31:0] k3);
    writeKey(0, k0); writeKey(1, k1); writeKey(2, k2); writeKey(3, k3);
  endtask

  // mid: 0 none, 1 extra start, 2 key write, 3 plaintext change
  task automatic runEnc(logic [63:0] blk, int mid,
                        output logic [63:0] ct, output int lat, output int busyCnt);
    @(negedge clk);
    ptIn = blk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    busyCnt = busy ? 1 : 0;
    while (!done && lat < 100) begin
      if (lat == 10) begin
        if (mid == 1) begin start = 1'b1; ptIn = ~blk; end
        if (mid == 2) begin keyWe = 1'b1; keyAddr = 2'd1; keyData = ~bk[1]; end
        if (mid == 3) ptIn = blk ^ 64'hFFFF_0000_FFFF_0000;
      end
      @(negedge clk);
      start = 1'b0;
      keyWe = 1'b0;
      lat++;
      if (busy) busyCnt++;
    end
    ct = ctOut;
  endtask

  task automatic encAndCheck(logic [63:0] blk, int mid, string req);
    logic [63:0] ct;
    int lat, bc;
    runEnc(blk, mid, ct, lat, bc);
    check({req, " latency"}, 64'(lat), 64'd32);
    check({req, " busy cycles"}, 64'(bc), 64'd32);
    check({req, " ciphertext"}, ct, expCt(blk));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [63:0] ct;
    logic [63:0] blk;
    int lat, bc;
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; ptIn = '0; keyWe = 1'b0; keyAddr = '0; keyData = '0;
    for (int i = 0; i < 4; i++) bk[i] = 32'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 ctOut", ctOut, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ctOut after release", ctOut, 64'd0);

    // R1 R5: all-zero key (reset value) and zero block
    encAndCheck(64'd0, 0, "R1 R5 zero key");

    // R2 R5: all ones
    loadKey(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    encAndCheck(64'hFFFF_FFFF_FFFF_FFFF, 0, "R2 R5 ones");

    // R6: only one key word nonzero at a time, exposes the index selection
    for (int w = 0; w < 4; w++) begin
      loadKey(w == 0 ? 32'h0123_4567 : 32'd0, w == 1 ? 32'h89AB_CDEF : 32'd0,
              w == 2 ? 32'hFEDC_BA98 : 32'd0, w == 3 ? 32'h7654_3210 : 32'd0);
      encAndCheck(64'h0000_0001_8000_0000, 0, "R6 key select");
    end

    // R3 R5: word placement, only v0 or only v1 set
    loadKey(32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888);
    encAndCheck(64'h0000_0000_DEAD_BEEF, 0, "R3 low word");
    encAndCheck(64'hDEAD_BEEF_0000_0000, 0, "R3 high word");

    // R2 R4 R5: random keys and blocks
    for (int t = 0; t < 12; t++) begin
      loadKey($urandom, $urandom, $urandom, $urandom);
      blk = {$urandom, $urandom};
      encAndCheck(blk, 0, "R2 R4 R5 random");
    end

    // R7: start while busy is ignored
    blk = {$urandom, $urandom};
    encAndCheck(blk, 1, "R7 restart ignored");

    // R8: key write while busy is ignored, now and later
    blk = {$urandom, $urandom};
    encAndCheck(blk, 2, "R8 key write busy");
    blk = {$urandom, $urandom};
    encAndCheck(blk, 0, "R8 key kept");

    // R3: plaintext change while busy has no effect
    blk = {$urandom, $urandom};
    encAndCheck(blk, 3, "R3 pt change busy");

    // R9: output holds while idle as ptIn moves
    blk = {$urandom, $urandom};
    runEnc(blk, 0, ct, lat, bc);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ptIn = {$urandom, $urandom};
    end
    @(negedge clk);
    check("R9 hold", ctOut, expCt(blk));
    check("R9 done low", 64'(done), 64'd0);
    check("R9 busy low", 64'(busy), 64'd0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule